// File: doc/BRIEF.md
# One-step converter state estimator

This block bridges the one-period computation delay of a finite-set predictive controller for a three-phase, three-cell stacked-capacitor converter. Each sampling instant the controller measures three load currents and two floating capacitor voltages per phase. The switch pattern chosen one period earlier is already applied at that point and stays fixed for the whole period. From these inputs the estimator projects the converter state one instant ahead. The downstream per-phase switch searches use the projection as their starting point. Their decision takes effect two instants after the measurement.

The estimator works out each phase's pole voltage from its applied switch bits and its own capacitor voltages. The dc-link voltage is a fixed parameter and is not measured. It then forms the load neutral voltage as one third of the three pole voltages. This coupling between the phases is kept here, while the later per-phase search drops it. The current estimates use the first-order load recursion. The capacitor estimates then use a trapezoidal update, which needs both the present current and the estimated current. All arithmetic is signed fixed point. Coefficient parameters carry `CF` fraction bits.

A sequencer steps through six states. ST_IDLE waits for `start`. On an accepted start the inputs are sampled and the sequencer moves to ST_VOLT, which registers the pole voltages. ST_NEUT registers the neutral voltage. ST_CURR registers the current estimates. ST_CAP registers the capacitor estimates and copies all nine results to the outputs. ST_DONE raises `est_valid` for one cycle. From ST_DONE the sequencer moves to ST_VOLT when `start` is high and to ST_IDLE when it is low.

Top module: `fc_step_estimator`

## Requirements
- R1: The pole voltage of phase p is S3·VDC − (S3−S2)·vc2 − (S2−S1)·vc1. S1, S2 and S3 are bits 0, 1 and 2 of `sw_app[3p+2:3p]`, and phase a is p=0. Each per-phase data bus carries phase p in bits `[p*DW +: DW]`, and the values are two's complement.
- R2: The neutral voltage is (sum of the three pole voltages × 21845 + 32768) shifted arithmetically right by 16. This is a rounded division by three.
- R3: Each current estimate is (KA·i + KB·(vpole − vneutral) + 2^(CF−1)) shifted arithmetically right by CF, and then saturated to the DW-bit signed range.
- R4: For each phase, t1 = (KC1·(i + i_est) + 2^(CF−1)) shifted arithmetically right by CF, where i_est is the saturated current estimate. The vc1 estimate is vc1 + t1 when S2−S1 = +1, vc1 − t1 when S2−S1 = −1, and vc1 unchanged when S2 = S1.
- R5: The vc2 estimate follows R4 with KC2 in place of KC1 and S3−S2 as the gate.
- R6: Both capacitor estimates saturate to the DW-bit signed range.
- R7: `est_valid` is high for exactly one cycle, after the fifth rising edge counted from the edge that accepts `start` (that edge included). All nine outputs change only on the edge that raises `est_valid`, and they hold their values at all other times.
- R8: `busy` is high during the four cycles between the accepting edge and the `est_valid` cycle. It is never high together with `est_valid`.
- R9: A `start` that is high while `busy` is high has no effect.
- R10: The inputs are sampled only on the accepting edge. Input changes after that edge do not affect the running estimate.
- R11: A `start` that is high in the `est_valid` cycle is accepted. The next result then follows back to back.
- R12: While `rst_n` is low, all outputs are zero and `busy` and `est_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new estimate from the present inputs |
| i_meas | input | 3*DW | Measured phase currents |
| vc1_meas | input | 3*DW | Measured low-cell capacitor voltages |
| vc2_meas | input | 3*DW | Measured middle-cell capacitor voltages |
| sw_app | input | 9 | Applied switch bits, three per phase |
| busy | output | 1 | Estimate in progress |
| est_valid | output | 1 | One-cycle pulse: outputs hold a new estimate |
| i_est | output | 3*DW | Estimated phase currents |
| vc1_est | output | 3*DW | Estimated low-cell capacitor voltages |
| vc2_est | output | 3*DW | Estimated middle-cell capacitor voltages |

## Verification
Two functions can fall in the same cycle. A result can be published with `est_valid` while the next request is accepted. A request can also arrive while the datapath is still busy. The bench provokes the first case by raising `start` exactly in the `est_valid` cycle with fresh inputs. It provokes the second by holding `start` through the busy window, and by changing the inputs right after acceptance. A behavioural model written with plain integers tracks the acceptance window and the expected results. It is compared with `busy`, `est_valid` and all nine outputs on every clock. A request that is wrongly accepted or dropped, or an early overwrite of the outputs, therefore shows up as a mismatch in the same cycle.

// File: rtl/fc_est_pkg.sv
package fc_est_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VOLT,
        ST_NEUT,
        ST_CURR,
        ST_CAP,
        ST_DONE
    } est_state_t;

    // difference of two switch bits: 0, +1 or -1
    typedef enum logic [1:0] {
        D_ZERO = 2'd0,
        D_POS  = 2'd1,
        D_NEG  = 2'd2
    } dsel_t;

    function automatic dsel_t diff_sel(logic hi, logic lo);
        if (hi && !lo) return D_POS;
        if (!hi && lo) return D_NEG;
        return D_ZERO;
    endfunction

    // clamp a wide signed value into a w-bit two's complement range
    function automatic logic signed [63:0] clamp(logic signed [63:0] x, int w);
        logic signed [63:0] hi;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        if (x > hi) return hi;
        if (x < (-hi - 64'sd1)) return -hi - 64'sd1;
        return x;
    endfunction

endpackage

// File: rtl/fc_tri_gate.sv
module fc_tri_gate
    import fc_est_pkg::*;
#(
    parameter int W = 18
) (
    input  dsel_t              sel,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);

    always_comb begin
        unique case (sel)
            D_POS:   y = x;
            D_NEG:   y = -x;
            D_ZERO:  y = '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/fc_phase_volt.sv
module fc_phase_volt
    import fc_est_pkg::*;
#(
    parameter int DW  = 16,
    parameter int VDC = 3200
) (
    input  logic [2:0]           sw,
    input  logic signed [DW-1:0] vc1,
    input  logic signed [DW-1:0] vc2,
    output logic signed [DW+1:0] vph
);

    localparam int PW = DW + 2;

    dsel_t               d_lo;
    dsel_t               d_hi;
    logic signed [PW-1:0] t_lo;
    logic signed [PW-1:0] t_hi;
    logic signed [PW-1:0] rail;

    assign d_lo = diff_sel(sw[1], sw[0]);
    assign d_hi = diff_sel(sw[2], sw[1]);

    fc_tri_gate #(.W(PW)) u_lo (.sel(d_lo), .x(PW'(vc1)), .y(t_lo));
    fc_tri_gate #(.W(PW)) u_hi (.sel(d_hi), .x(PW'(vc2)), .y(t_hi));

    assign rail = sw[2] ? PW'(VDC) : '0;
    assign vph  = rail - t_hi - t_lo;

endmodule

// File: rtl/fc_cap_step.sv
module fc_cap_step
    import fc_est_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int CF   = 14,
    parameter int COEF = 328
) (
    input  dsel_t                sel,
    input  logic signed [DW-1:0] vc,
    input  logic signed [DW-1:0] i_now,
    input  logic signed [DW-1:0] i_nxt,
    output logic signed [DW-1:0] vc_nxt
);

    localparam int SW   = DW + 1;
    localparam int PW   = CW + SW + 1;
    localparam int AW   = PW + 1;
    localparam int HALF = 2 ** (CF - 1);

    logic signed [SW-1:0] isum;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] step;
    logic signed [PW-1:0] gated;
    logic signed [AW-1:0] acc;

    assign isum = SW'(i_now) + SW'(i_nxt);
    assign prod = PW'(COEF) * PW'(isum) + PW'(HALF);
    assign step = prod >>> CF;

    fc_tri_gate #(.W(PW)) u_gate (.sel(sel), .x(step), .y(gated));

    assign acc    = AW'(vc) + AW'(gated);
    assign vc_nxt = DW'(clamp(64'(acc), DW));

endmodule

// File: rtl/fc_est_fsm.sv
module fc_est_fsm
    import fc_est_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ld_in,
    output logic ld_volt,
    output logic ld_neut,
    output logic ld_curr,
    output logic ld_out,
    output logic busy,
    output logic done
);

    est_state_t st;
    est_state_t st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_VOLT;
            ST_VOLT: st_nx = ST_NEUT;
            ST_NEUT: st_nx = ST_CURR;
            ST_CURR: st_nx = ST_CAP;
            ST_CAP:  st_nx = ST_DONE;
            ST_DONE: st_nx = start ? ST_VOLT : ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_in   = 1'b0;
        ld_volt = 1'b0;
        ld_neut = 1'b0;
        ld_curr = 1'b0;
        ld_out  = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (st)
            ST_IDLE: ld_in = start;
            ST_VOLT: begin ld_volt = 1'b1; busy = 1'b1; end
            ST_NEUT: begin ld_neut = 1'b1; busy = 1'b1; end
            ST_CURR: begin ld_curr = 1'b1; busy = 1'b1; end
            ST_CAP:  begin ld_out  = 1'b1; busy = 1'b1; end
            ST_DONE: begin done = 1'b1; ld_in = start; end
            default: ;
        endcase
    end

endmodule

// File: rtl/fc_step_estimator.sv
module fc_step_estimator
    import fc_est_pkg::*;
#(
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int CF  = 14,
    parameter int VDC = 3200,
    parameter int KA  = 15565,
    parameter int KB  = 1638,
    parameter int KC1 = 328,
    parameter int KC2 = 164
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3*DW-1:0] i_meas,
    input  logic [3*DW-1:0] vc1_meas,
    input  logic [3*DW-1:0] vc2_meas,
    input  logic [8:0]      sw_app,
    output logic            busy,
    output logic            est_valid,
    output logic [3*DW-1:0] i_est,
    output logic [3*DW-1:0] vc1_est,
    output logic [3*DW-1:0] vc2_est
);

    localparam int NPH   = 3;
    localparam int PW    = DW + 2;
    localparam int SUMW  = DW + 4;
    localparam int RF    = 16;
    localparam int RECIP = (2 ** RF + 1) / 3;
    localparam int NPW   = SUMW + RF + 2;
    localparam int DVW   = PW + 1;
    localparam int ACW   = CW + DVW + 2;
    localparam int HALF  = 2 ** (CF - 1);

    logic ld_in, ld_volt, ld_neut, ld_curr, ld_out, done;

    logic signed [DW-1:0] i_r   [NPH];
    logic signed [DW-1:0] vc1_r [NPH];
    logic signed [DW-1:0] vc2_r [NPH];
    logic [8:0]           sw_r;
    logic signed [PW-1:0] vph_c [NPH];
    logic signed [PW-1:0] vph_r [NPH];
    logic signed [PW-1:0] vn_c;
    logic signed [PW-1:0] vn_r;
    logic signed [DW-1:0] inx_c [NPH];
    logic signed [DW-1:0] inx_r [NPH];
    logic signed [DW-1:0] vc1_c [NPH];
    logic signed [DW-1:0] vc2_c [NPH];
    logic signed [DW-1:0] i_o   [NPH];
    logic signed [DW-1:0] vc1_o [NPH];
    logic signed [DW-1:0] vc2_o [NPH];

    fc_est_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .ld_in  (ld_in),
        .ld_volt(ld_volt),
        .ld_neut(ld_neut),
        .ld_curr(ld_curr),
        .ld_out (ld_out),
        .busy   (busy),
        .done   (done)
    );

    assign est_valid = done;

    // neutral voltage: rounded multiply by reciprocal of three
    logic signed [SUMW-1:0] vsum;
    logic signed [NPW-1:0]  vprod;
    assign vsum  = SUMW'(vph_r[0]) + SUMW'(vph_r[1]) + SUMW'(vph_r[2]);
    assign vprod = NPW'(vsum) * NPW'(RECIP) + NPW'(2 ** (RF - 1));
    assign vn_c  = PW'(vprod >>> RF);

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        dsel_t                 d_lo;
        dsel_t                 d_hi;
        logic signed [DVW-1:0] dv;
        logic signed [ACW-1:0] acc;

        fc_phase_volt #(.DW(DW), .VDC(VDC)) u_pv (
            .sw (sw_r[3*p +: 3]),
            .vc1(vc1_r[p]),
            .vc2(vc2_r[p]),
            .vph(vph_c[p])
        );

        assign dv       = DVW'(vph_r[p]) - DVW'(vn_r);
        assign acc      = ACW'(KA) * ACW'(i_r[p]) + ACW'(KB) * ACW'(dv) + ACW'(HALF);
        assign inx_c[p] = DW'(clamp(64'(acc >>> CF), DW));

        assign d_lo = diff_sel(sw_r[3*p + 1], sw_r[3*p]);
        assign d_hi = diff_sel(sw_r[3*p + 2], sw_r[3*p + 1]);

        fc_cap_step #(.DW(DW), .CW(CW), .CF(CF), .COEF(KC1)) u_c1 (
            .sel   (d_lo),
            .vc    (vc1_r[p]),
            .i_now (i_r[p]),
            .i_nxt (inx_r[p]),
            .vc_nxt(vc1_c[p])
        );

        fc_cap_step #(.DW(DW), .CW(CW), .CF(CF), .COEF(KC2)) u_c2 (
            .sel   (d_hi),
            .vc    (vc2_r[p]),
            .i_now (i_r[p]),
            .i_nxt (inx_r[p]),
            .vc_nxt(vc2_c[p])
        );

        assign i_est  [p*DW +: DW] = i_o[p];
        assign vc1_est[p*DW +: DW] = vc1_o[p];
        assign vc2_est[p*DW +: DW] = vc2_o[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_r <= '0;
            vn_r <= '0;
            for (int p = 0; p < NPH; p++) begin
                i_r[p]   <= '0;
                vc1_r[p] <= '0;
                vc2_r[p] <= '0;
                vph_r[p] <= '0;
                inx_r[p] <= '0;
                i_o[p]   <= '0;
                vc1_o[p] <= '0;
                vc2_o[p] <= '0;
            end
        end else begin
            if (ld_in) begin
                sw_r <= sw_app;
                for (int p = 0; p < NPH; p++) begin
                    i_r[p]   <= i_meas[p*DW +: DW];
                    vc1_r[p] <= vc1_meas[p*DW +: DW];
                    vc2_r[p] <= vc2_meas[p*DW +: DW];
                end
            end
            if (ld_volt) begin
                for (int p = 0; p < NPH; p++) vph_r[p] <= vph_c[p];
            end
            if (ld_neut) vn_r <= vn_c;
            if (ld_curr) begin
                for (int p = 0; p < NPH; p++) inx_r[p] <= inx_c[p];
            end
            if (ld_out) begin
                for (int p = 0; p < NPH; p++) begin
                    i_o[p]   <= inx_r[p];
                    vc1_o[p] <= vc1_c[p];
                    vc2_o[p] <= vc2_c[p];
                end
            end
        end
    end

endmodule

// File: rtl/fc_step_estimator_chk.sv
module fc_step_estimator_chk #(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            est_valid,
    input logic [3*DW-1:0] i_est,
    input logic [3*DW-1:0] vc1_est,
    input logic [3*DW-1:0] vc2_est
);

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |=> !est_valid);

    assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !est_valid |-> ($stable(i_est) && $stable(vc1_est) && $stable(vc2_est)));

    assert_valid_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |-> $past(busy));

    assert_busy_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && est_valid));

    assert_busy_ends_in_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> est_valid);

    assert_busy_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || est_valid));

    assert_busy_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind fc_step_estimator fc_step_estimator_chk #(.DW(DW)) chk_i (.*);

// File: tb/fc_step_estimator_tb_top.sv
`timescale 1ns/1ps
module fc_step_estimator_tb_top;

    localparam int DW  = 16;
    localparam int CW  = 16;
    localparam int CF  = 14;
    localparam int VDC = 3200;
    localparam int KA  = 15565;
    localparam int KB  = 1638;
    localparam int KC1 = 328;
    localparam int KC2 = 164;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [3*DW-1:0] i_meas = '0;
    logic [3*DW-1:0] vc1_meas = '0;
    logic [3*DW-1:0] vc2_meas = '0;
    logic [8:0]      sw_app = '0;
    logic            busy;
    logic            est_valid;
    logic [3*DW-1:0] i_est;
    logic [3*DW-1:0] vc1_est;
    logic [3*DW-1:0] vc2_est;

    int    n_chk = 0;
    int    n_bad = 0;
    int    n_pulse = 0;
    bit    chk_on = 1'b0;
    bit    finished = 1'b0;
    string scen = "reset";

    always #2.5 clk = ~clk;

    fc_step_estimator #(
        .DW(DW), .CW(CW), .CF(CF), .VDC(VDC),
        .KA(KA), .KB(KB), .KC1(KC1), .KC2(KC2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .i_meas(i_meas), .vc1_meas(vc1_meas), .vc2_meas(vc2_meas),
        .sw_app(sw_app), .busy(busy), .est_valid(est_valid),
        .i_est(i_est), .vc1_est(vc1_est), .vc2_est(vc2_est)
    );

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, scen, act, exp);
        end
    endtask

    function automatic longint sat(longint x);
        longint hi = (longint'(1) <<< (DW - 1)) - 1;
        if (x > hi) return hi;
        if (x < -hi - 1) return -hi - 1;
        return x;
    endfunction

    // behavioural reference model
    int     mcnt = 0;
    longint m_i [3] = '{0, 0, 0};
    longint m_v1[3] = '{0, 0, 0};
    longint m_v2[3] = '{0, 0, 0};
    longint p_i [3] = '{0, 0, 0};
    longint p_v1[3] = '{0, 0, 0};
    longint p_v2[3] = '{0, 0, 0};

    always @(posedge clk) begin : model
        longint vp[3];
        longint ci, c1, c2, vn, t1, t2;
        int     b1, b2, b3;
        if (!rst_n) begin
            mcnt = 0;
            for (int p = 0; p < 3; p++) begin m_i[p] = 0; m_v1[p] = 0; m_v2[p] = 0; end
        end else begin
            if ((mcnt == 0 || mcnt == 5) && start) begin
                for (int p = 0; p < 3; p++) begin
                    b1 = sw_app[3*p] ? 1 : 0;
                    b2 = sw_app[3*p+1] ? 1 : 0;
                    b3 = sw_app[3*p+2] ? 1 : 0;
                    c1 = longint'($signed(vc1_meas[p*DW +: DW]));
                    c2 = longint'($signed(vc2_meas[p*DW +: DW]));
                    vp[p] = b3 * VDC - (b3 - b2) * c2 - (b2 - b1) * c1;
                end
                vn = ((vp[0] + vp[1] + vp[2]) * 21845 + 32768) >>> 16;
                for (int p = 0; p < 3; p++) begin
                    b1 = sw_app[3*p] ? 1 : 0;
                    b2 = sw_app[3*p+1] ? 1 : 0;
                    b3 = sw_app[3*p+2] ? 1 : 0;
                    ci = longint'($signed(i_meas[p*DW +: DW]));
                    c1 = longint'($signed(vc1_meas[p*DW +: DW]));
                    c2 = longint'($signed(vc2_meas[p*DW +: DW]));
                    p_i[p] = sat((KA * ci + KB * (vp[p] - vn) + (longint'(1) <<< (CF - 1))) >>> CF);
                    t1 = (KC1 * (ci + p_i[p]) + (longint'(1) <<< (CF - 1))) >>> CF;
                    t2 = (KC2 * (ci + p_i[p]) + (longint'(1) <<< (CF - 1))) >>> CF;
                    p_v1[p] = sat(c1 + (b2 - b1) * t1);
                    p_v2[p] = sat(c2 + (b3 - b2) * t2);
                end
                mcnt = 1;
            end else if (mcnt == 5) begin
                mcnt = 0;
            end else if (mcnt != 0) begin
                mcnt = mcnt + 1;
            end
            if (mcnt == 5) begin
                for (int p = 0; p < 3; p++) begin
                    m_i[p] = p_i[p]; m_v1[p] = p_v1[p]; m_v2[p] = p_v2[p];
                end
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            if (est_valid) n_pulse++;
            check("R7", longint'(est_valid), longint'(mcnt == 5));
            check("R8", longint'(busy), longint'(mcnt >= 1 && mcnt <= 4));
            for (int p = 0; p < 3; p++) begin
                check("R3", longint'($signed(i_est[p*DW +: DW])), m_i[p]);
                check("R4", longint'($signed(vc1_est[p*DW +: DW])), m_v1[p]);
                check("R5", longint'($signed(vc2_est[p*DW +: DW])), m_v2[p]);
            end
        end
    end

    task automatic load(int i0, int i1, int i2, int a0, int a1, int a2,
                        int b0, int b1, int b2, logic [8:0] sw);
        i_meas   = {DW'(i2), DW'(i1), DW'(i0)};
        vc1_meas = {DW'(a2), DW'(a1), DW'(a0)};
        vc2_meas = {DW'(b2), DW'(b1), DW'(b0)};
        sw_app   = sw;
    endtask

    task automatic run_one(string nm);
        scen = nm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog [%s] actual=timeout expected=done", scen);
        wrap_up();
    end

    initial begin
        int pc;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", longint'(busy), 0);
        check("R12", longint'(est_valid), 0);
        check("R12", longint'(i_est | vc1_est | vc2_est), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;

        load(100, -200, 300, 400, 500, 600, 800, 1000, 1200, 9'b000_000_000);
        run_one("R1 R3 all switches low");
        load(1500, -900, 250, 600, 700, 500, 1300, 1200, 1100, 9'b100_001_010);
        run_one("R4 R5 gates +1 -1 0");
        load(-2500, -1800, -700, 1000, 900, 1100, 2100, 2000, 1900, 9'b110_011_111);
        run_one("R1 R2 neutral coupling mixed");
        load(32767, 30000, -32768, 0, 32700, -32700, -32768, 0, 32000, 9'b011_010_100);
        run_one("R3 R6 saturation extremes");

        // R10: inputs changed right after acceptance
        load(700, 800, 900, 300, 300, 300, 600, 600, 600, 9'b010_010_010);
        scen = "R10 capture on accept";
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        load(-5000, 5000, 0, 9000, -9000, 1, 2, 3, 4, 9'b111_000_101);
        repeat (6) @(negedge clk);

        // R9: start held through the busy window
        load(1200, 1300, -2500, 450, 350, 250, 900, 700, 500, 9'b001_110_011);
        scen = "R9 start ignored while busy";
        pc = n_pulse;
        start = 1'b1;
        repeat (4) @(negedge clk);
        load(-1, -1, -1, -1, -1, -1, -1, -1, -1, 9'b111_111_111);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check("R9", longint'(n_pulse - pc), 1);

        // R11: new start in the valid cycle
        load(2000, -1000, -1000, 500, 400, 300, 1000, 800, 600, 9'b010_100_001);
        scen = "R11 back to back";
        pc = n_pulse;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!est_valid) @(negedge clk);
        load(-3000, 1500, 1500, 250, 450, 650, 700, 900, 1100, 9'b101_110_010);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check("R11", longint'(n_pulse - pc), 2);

        // mixed patterns across the whole range
        for (int k = 0; k < 40; k++) begin
            load(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 8000)) - 4000,
                 int'($urandom_range(0, 8000)) - 4000, int'($urandom_range(0, 65535)) - 32768,
                 int'($urandom_range(0, 2000)), int'($urandom_range(0, 2000)),
                 int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 3000)),
                 int'($urandom_range(0, 3000)), 9'($urandom_range(0, 511)));
            run_one("R1 R2 R3 R4 R5 R6 mixed patterns");
        end

        wrap_up();
    end

endmodule